// File: doc/BRIEF.md
# Byte-to-10-bit line encoder with forced disparity

This block turns one byte per clock into a 10-bit, DC-balanced, run-length-limited code word using the well-known 8b10b code. Each cycle it takes a byte, a valid strobe, a select that marks the byte as a control character, and a 2-bit balance field. It returns a registered 10-bit word and a flag that reports a request for a control code that does not exist. A running-disparity state picks between the two encodings of each character, so the cumulative line disparity stays bounded.

When no valid input is offered, the block emits the comma/idle control character K28.5, so the line never goes quiet. The balance field lets the user force the positive-weight or the negative-weight encoding of the current character, which allows a resynchronisation pattern to be built. Word bit 0 is the first bit on the line. Serialisation and the analog line interface sit outside this block.

Top module: `byte_linecoder`

## Requirements
- R1: The output is registered with one cycle of latency. The word driven before a clock edge shows up on `code_word` only after that edge. While reset is held (synchronous, active low), `code_word` is all zeros and `ctrl_err` is low.
- R2: Running disparity leaves reset negative, so an idle sent straight after reset (with only neutral words before it) is the negative-state K28.5 word 10'h17C.
- R3: While `in_valid` is low, `in_byte`, `in_ctrl` and `in_bal` are ignored. The word is K28.5: 10'h17C when running disparity is negative, 10'h283 when it is positive. `ctrl_err` stays low.
- R4: Byte bits [4:0] form the 5-bit group and bits [7:5] the 3-bit group. Word bits 0..5 carry the 6-bit sub-block in line order and bits 6..9 the 4-bit sub-block. Examples at negative disparity: D0.0 (8'h00) gives 10'h0B9, D17.7 (8'hF1) gives 10'h3B1 (the alternate x.7 form), and D21.5 (8'hB5) gives 10'h155.
- R5: With balance code 00, every word has 4, 5 or 6 ones. Six ones only appear when running disparity is negative, and four ones only when it is positive. The serial stream never holds more than five equal bits in a row.
- R6: In each disparity state, the 256 data bytes map to 256 distinct words.
- R7: The legal control codes are the twelve bytes with bits [4:0] = 28 (any bits [7:5]) plus bits [7:5] = 7 with bits [4:0] in {23, 27, 29, 30}. K28.y words start with sub-block 001111 (negative state) or 110000 (positive state). K28.7 at negative disparity gives 10'h07C and K23.7 gives 10'h057.
- R8: A valid control request for any other byte raises `ctrl_err` alongside its word. That word is K28.5 at the current disparity. `ctrl_err` is low in every other case.
- R9: For a valid data byte, balance code 01 sends the encoding used at negative running disparity (at least five ones). Code 10 sends the encoding used at positive running disparity (at most five ones). This holds whatever the current state.
- R10: A character with a single, neutral encoding (for example D21.5) comes out identically under balance codes 00, 01 and 10.
- R11: After any word, running disparity becomes positive if the word had six ones, negative if it had four, and is otherwise unchanged. This includes forced words.
- R12: The reserved balance code 11 behaves exactly like code 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, hold at least five cycles |
| in_valid | input | 1 | Byte is to be sent; when low an idle is sent |
| in_ctrl | input | 1 | Byte names a control character |
| in_byte | input | 8 | Data or control byte |
| in_bal | input | 2 | Balance: 00 auto, 01 force positive, 10 force negative, 11 reserved (auto) |
| code_word | output | 10 | Encoded word, bit 0 sent first |
| ctrl_err | output | 1 | Illegal control code requested this word |

## Verification
All 256 bytes go through as data in both disparity states. This separates a correct table from one with a swapped or mistyped entry, using injectivity, weight rules and the run-length limit across word boundaries. All 256 bytes then go through as control requests, which separates the twelve legal codes from near misses. Forced-balance sweeps, each followed by an idle, show whether the forced column was chosen and whether the state afterwards follows the weight of the word actually sent. Idles with junk byte, select and balance values show that those inputs are ignored.

// File: rtl/linecode_pkg.sv
package linecode_pkg;

   typedef enum logic {
      RD_NEG = 1'b0,
      RD_POS = 1'b1
   } rd_e;

   typedef enum logic [1:0] {
      BAL_AUTO  = 2'b00,
      BAL_PLUS  = 2'b01,
      BAL_MINUS = 2'b10,
      BAL_RSVD  = 2'b11
   } bal_e;

   localparam int unsigned LC_SUB6_W  = 6;
   localparam int unsigned LC_SUB4_W  = 4;
   localparam logic [4:0]  LC_KX_MAIN = 5'd28;

   // table entries are written first-sent bit on the left; flip to word order
   function automatic logic [LC_SUB6_W-1:0] lc_flip6(input logic [LC_SUB6_W-1:0] v);
      logic [LC_SUB6_W-1:0] r;
      for (int i = 0; i < LC_SUB6_W; i++) r[i] = v[LC_SUB6_W-1-i];
      return r;
   endfunction

   function automatic logic [LC_SUB4_W-1:0] lc_flip4(input logic [LC_SUB4_W-1:0] v);
      logic [LC_SUB4_W-1:0] r;
      for (int i = 0; i < LC_SUB4_W; i++) r[i] = v[LC_SUB4_W-1-i];
      return r;
   endfunction

   function automatic rd_e lc_invert(input rd_e v);
      return (v == RD_NEG) ? RD_POS : RD_NEG;
   endfunction

endpackage

// File: rtl/lc_kcheck.sv
module lc_kcheck
   import linecode_pkg::*;
#(
   parameter int unsigned N_Y7 = 4
)(
   input  logic [4:0] x_i,
   input  logic [2:0] y_i,
   output logic       legal_o
);
   localparam logic [4:0] Y7_X [N_Y7] = '{5'd23, 5'd27, 5'd29, 5'd30};

   logic [N_Y7-1:0] hit;

   for (genvar g = 0; g < N_Y7; g++) begin : g_y7
      assign hit[g] = (x_i == Y7_X[g]);
   end

   assign legal_o = (x_i == LC_KX_MAIN) || ((y_i == 3'd7) && (|hit));
endmodule

// File: rtl/lc_sub6.sv
module lc_sub6
   import linecode_pkg::*;
(
   input  logic [4:0]           x_i,
   input  logic                 k_i,
   input  rd_e                  rd_i,
   output logic [LC_SUB6_W-1:0] code_o,
   output rd_e                  rd_o
);
   logic [LC_SUB6_W-1:0] neg_col;
   logic                 unbal;
   logic                 swap;

   always_comb begin
      unique case (x_i)
         5'd0 : neg_col = 6'b100111;
         5'd1 : neg_col = 6'b011101;
         5'd2 : neg_col = 6'b101101;
         5'd3 : neg_col = 6'b110001;
         5'd4 : neg_col = 6'b110101;
         5'd5 : neg_col = 6'b101001;
         5'd6 : neg_col = 6'b011001;
         5'd7 : neg_col = 6'b111000;
         5'd8 : neg_col = 6'b111001;
         5'd9 : neg_col = 6'b100101;
         5'd10: neg_col = 6'b010101;
         5'd11: neg_col = 6'b110100;
         5'd12: neg_col = 6'b001101;
         5'd13: neg_col = 6'b101100;
         5'd14: neg_col = 6'b011100;
         5'd15: neg_col = 6'b010111;
         5'd16: neg_col = 6'b011011;
         5'd17: neg_col = 6'b100011;
         5'd18: neg_col = 6'b010011;
         5'd19: neg_col = 6'b110010;
         5'd20: neg_col = 6'b001011;
         5'd21: neg_col = 6'b101010;
         5'd22: neg_col = 6'b011010;
         5'd23: neg_col = 6'b111010;
         5'd24: neg_col = 6'b110011;
         5'd25: neg_col = 6'b100110;
         5'd26: neg_col = 6'b010110;
         5'd27: neg_col = 6'b110110;
         5'd28: neg_col = k_i ? 6'b001111 : 6'b001110;
         5'd29: neg_col = 6'b101110;
         5'd30: neg_col = 6'b011110;
         default: neg_col = 6'b101011;
      endcase
   end

   assign unbal  = ($countones(neg_col) != 3);
   assign swap   = (unbal || (x_i == 5'd7)) && (rd_i == RD_POS);
   assign code_o = lc_flip6(swap ? ~neg_col : neg_col);
   assign rd_o   = unbal ? lc_invert(rd_i) : rd_i;
endmodule

// File: rtl/lc_sub4.sv
module lc_sub4
   import linecode_pkg::*;
(
   input  logic [2:0]           y_i,
   input  logic [4:0]           x_i,
   input  logic                 k_i,
   input  rd_e                  rd_i,
   output logic [LC_SUB4_W-1:0] code_o
);
   logic [LC_SUB4_W-1:0] neg_col;
   logic                 alt7;
   logic                 swap;

   always_comb begin
      alt7 = 1'b0;
      if (y_i == 3'd7 && !k_i) begin
         if (rd_i == RD_NEG)
            alt7 = (x_i == 5'd17) || (x_i == 5'd18) || (x_i == 5'd20);
         else
            alt7 = (x_i == 5'd11) || (x_i == 5'd13) || (x_i == 5'd14);
      end
   end

   always_comb begin
      unique case (y_i)
         3'd0:    neg_col = 4'b1011;
         3'd1:    neg_col = k_i ? 4'b0110 : 4'b1001;
         3'd2:    neg_col = k_i ? 4'b1010 : 4'b0101;
         3'd3:    neg_col = 4'b1100;
         3'd4:    neg_col = 4'b1101;
         3'd5:    neg_col = k_i ? 4'b0101 : 4'b1010;
         3'd6:    neg_col = k_i ? 4'b1001 : 4'b0110;
         default: neg_col = (k_i || alt7) ? 4'b0111 : 4'b1110;
      endcase
   end

   assign swap   = (($countones(neg_col) != 2) || (y_i == 3'd3) || k_i) && (rd_i == RD_POS);
   assign code_o = lc_flip4(swap ? ~neg_col : neg_col);
endmodule

// File: rtl/byte_linecoder.sv
module byte_linecoder
   import linecode_pkg::*;
#(
   parameter int unsigned BYTE_W       = 8,
   parameter bit          RESET_RD_POS = 1'b0,
   parameter logic [2:0]  IDLE_Y       = 3'd5
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic                         in_ctrl,
   input  logic [BYTE_W-1:0]            in_byte,
   input  logic [1:0]                   in_bal,
   output logic [BYTE_W+BYTE_W/4-1:0]   code_word,
   output logic                         ctrl_err
);
   localparam int unsigned CODE_W  = BYTE_W + BYTE_W/4;
   localparam int unsigned X_W     = 5;
   localparam int unsigned ONES_W  = $clog2(CODE_W + 1);
   localparam int unsigned HALF_W  = CODE_W / 2;
   localparam rd_e         RD_INIT = RESET_RD_POS ? RD_POS : RD_NEG;

   if (BYTE_W != 8) begin : g_bad_byte_w
      $error("byte_linecoder: BYTE_W must be 8");
   end
   if (!(IDLE_Y == 3'd1 || IDLE_Y == 3'd5 || IDLE_Y == 3'd7)) begin : g_bad_idle
      $error("byte_linecoder: IDLE_Y must name a comma character");
   end

   rd_e                 rd_q;
   rd_e                 rd_eff;
   rd_e                 rd_mid;
   rd_e                 rd_next;
   bal_e                bal_c;
   logic                k_legal;
   logic                bad_k;
   logic                use_idle;
   logic [BYTE_W-1:0]   sel_byte;
   logic                sel_k;
   logic [LC_SUB6_W-1:0] sub6;
   logic [LC_SUB4_W-1:0] sub4;
   logic [CODE_W-1:0]   word_c;
   logic [ONES_W-1:0]   ones_c;

   lc_kcheck u_kcheck (
      .x_i     (in_byte[X_W-1:0]),
      .y_i     (in_byte[BYTE_W-1:X_W]),
      .legal_o (k_legal)
   );

   assign bad_k    = in_valid && in_ctrl && !k_legal;
   assign use_idle = !in_valid || bad_k;
   assign sel_byte = use_idle ? {IDLE_Y, LC_KX_MAIN} : in_byte;
   assign sel_k    = use_idle || in_ctrl;
   assign bal_c    = bal_e'(in_bal);

   // forcing applies only to a character the user actually supplied
   always_comb begin
      rd_eff = rd_q;
      if (!use_idle) begin
         unique case (bal_c)
            BAL_PLUS:  rd_eff = RD_NEG;
            BAL_MINUS: rd_eff = RD_POS;
            default:   rd_eff = rd_q;
         endcase
      end
   end

   lc_sub6 u_sub6 (
      .x_i    (sel_byte[X_W-1:0]),
      .k_i    (sel_k),
      .rd_i   (rd_eff),
      .code_o (sub6),
      .rd_o   (rd_mid)
   );

   lc_sub4 u_sub4 (
      .y_i    (sel_byte[BYTE_W-1:X_W]),
      .x_i    (sel_byte[X_W-1:0]),
      .k_i    (sel_k),
      .rd_i   (rd_mid),
      .code_o (sub4)
   );

   assign word_c = {sub4, sub6};
   assign ones_c = ONES_W'($countones(word_c));

   always_comb begin
      if (ones_c > ONES_W'(HALF_W))      rd_next = RD_POS;
      else if (ones_c < ONES_W'(HALF_W)) rd_next = RD_NEG;
      else                               rd_next = rd_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q      <= RD_INIT;
         code_word <= '0;
         ctrl_err  <= 1'b0;
      end else begin
         rd_q      <= rd_next;
         code_word <= word_c;
         ctrl_err  <= bad_k;
      end
   end
endmodule

// File: rtl/lc_checker.sv
module lc_checker
   import linecode_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ctrl,
   input logic [1:0] in_bal,
   input logic [9:0] code_word,
   input logic       ctrl_err
);
   localparam logic [9:0] IDLE_N = 10'h17C;
   localparam logic [9:0] IDLE_P = 10'h283;

   logic started;
   rd_e  rd_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started <= 1'b0;
         rd_seen <= RD_NEG;
      end else begin
         started <= 1'b1;
         if (started && $countones(code_word) == 6) rd_seen <= RD_POS;
         else if (started && $countones(code_word) == 4) rd_seen <= RD_NEG;
      end
   end

   AST_WEIGHT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> ($countones(code_word) >= 4 && $countones(code_word) <= 6)); // R5

   AST_IDLE_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ((code_word == IDLE_N || code_word == IDLE_P) && !ctrl_err)); // R3

   AST_ERR_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_err |-> $past(in_valid && in_ctrl)); // R8

   AST_ERR_GIVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_err |-> (code_word == IDLE_N || code_word == IDLE_P)); // R8

   AST_FORCE_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ctrl && in_bal == 2'b01) |=> ($countones(code_word) >= 5)); // R9

   AST_FORCE_MINUS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ctrl && in_bal == 2'b10) |=> ($countones(code_word) <= 5)); // R9

   AST_HEAVY_FROM_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !$past(in_valid && (in_bal == 2'b01 || in_bal == 2'b10))
       && $countones(code_word) == 6) |-> (rd_seen == RD_NEG)); // R5

   AST_LIGHT_FROM_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !$past(in_valid && (in_bal == 2'b01 || in_bal == 2'b10))
       && $countones(code_word) == 4) |-> (rd_seen == RD_POS)); // R5
endmodule

bind byte_linecoder lc_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ctrl   (in_ctrl),
   .in_bal    (in_bal),
   .code_word (code_word),
   .ctrl_err  (ctrl_err)
);

// File: tb/byte_linecoder_tb_top.sv
module byte_linecoder_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       valid;
   logic       ctrl;
   logic [7:0] byte_in;
   logic [1:0] bal;
   logic [9:0] word;
   logic       err;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   bit         brd = 0;
   bit         rd_before = 0;
   logic [9:0] last_word;
   logic       last_err;
   bit         run_bit = 0;
   int         run_len = 0;
   bit         run_chk = 0;
   logic [9:0] cw [2][256];

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_linecoder dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (valid),
      .in_ctrl   (ctrl),
      .in_byte   (byte_in),
      .in_bal    (bal),
      .code_word (word),
      .ctrl_err  (err)
   );

   task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] idle_for(input bit rd);
      return rd ? 10'h283 : 10'h17C;
   endfunction

   task automatic drive(input logic v, input logic c, input logic [7:0] b, input logic [1:0] bl);
      @(negedge clk);
      valid = v; ctrl = c; byte_in = b; bal = bl;
   endtask

   task automatic observe();
      bit bad;
      int ones;
      bad = 0;
      last_word = word;
      last_err  = err;
      for (int i = 0; i < 10; i++) begin
         if (run_len > 0 && word[i] == run_bit) run_len++;
         else begin run_bit = word[i]; run_len = 1; end
         if (run_len > 5) bad = 1;
      end
      if (run_chk) chk("R5 run length", {9'd0, bad}, 10'd0);
      rd_before = brd;
      ones = $countones(word);
      if (ones == 6) brd = 1;
      else if (ones == 4) brd = 0;
   endtask

   task automatic step(input logic v, input logic c, input logic [7:0] b, input logic [1:0] bl);
      drive(v, c, b, bl);
      @(posedge clk); #1;
      observe();
   endtask

   task automatic set_rd(input bit want);
      if (brd != want) begin
         step(1'b0, 1'b0, 8'h00, 2'b00);
         chk("R3 idle", last_word, idle_for(rd_before));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; valid = 1; ctrl = 0; byte_in = 8'h3C; bal = 2'b00;
      repeat (6) @(posedge clk);
      #1;
      chk("R1 reset word", word, 10'h000);
      chk("R1 reset err", {9'd0, err}, 10'd0);

      // R1: latency, new word only after the edge
      @(negedge clk);
      rst_n = 1; valid = 1; ctrl = 0; byte_in = 8'hB5; bal = 2'b00;
      @(posedge clk); #1;
      observe();
      chk("R4 D21.5", last_word, 10'h155);
      drive(1'b1, 1'b0, 8'h00, 2'b00);
      #(CLK_PERIOD/2 - 1);
      chk("R1 before edge", word, 10'h155);
      @(posedge clk); #1;
      observe();
      chk("R1 after edge D0.0", last_word, 10'h0B9);

      // R2: disparity negative after reset
      step(1'b0, 1'b1, 8'h55, 2'b01);
      chk("R2 first idle", last_word, 10'h17C);

      // R3: idles with junk inputs
      for (int i = 0; i < 12; i++) begin
         step(1'b0, i[0], 8'(i * 37 + 3), 2'(i));
         chk("R3 idle", last_word, idle_for(rd_before));
         chk("R3 no err", {9'd0, last_err}, 10'd0);
      end

      // R4 / R7 literal words
      set_rd(0);
      step(1'b1, 1'b0, 8'h00, 2'b00);
      chk("R4 D0.0", last_word, 10'h0B9);
      set_rd(0);
      step(1'b1, 1'b0, 8'hF1, 2'b00);
      chk("R4 D17.7", last_word, 10'h3B1);
      set_rd(1);
      step(1'b1, 1'b1, 8'hBC, 2'b00);
      chk("R7 K28.5 pos", last_word, 10'h283);
      set_rd(0);
      step(1'b1, 1'b1, 8'hFC, 2'b00);
      chk("R7 K28.7", last_word, 10'h07C);
      set_rd(0);
      step(1'b1, 1'b1, 8'hF7, 2'b00);
      chk("R7 K23.7", last_word, 10'h057);

      // R5 / R6: full data sweep in both states
      run_chk = 1;
      for (int p = 0; p < 2; p++) begin
         for (int b = 0; b < 256; b++) begin
            bit okw;
            int ones;
            set_rd(p[0]);
            step(1'b1, 1'b0, 8'(b), 2'b00);
            cw[p][b] = last_word;
            ones = $countones(last_word);
            okw = (ones >= 4 && ones <= 6) && !(ones == 6 && rd_before) && !(ones == 4 && !rd_before);
            chk("R5 weight rule", {9'd0, okw}, 10'd1);
         end
      end
      for (int p = 0; p < 2; p++) begin
         int dups;
         dups = 0;
         for (int a = 0; a < 256; a++)
            for (int b = a + 1; b < 256; b++)
               if (cw[p][a] == cw[p][b]) dups++;
         chk("R6 distinct words", 10'(dups), 10'd0);
      end

      // R7 / R8: control sweep
      for (int b = 0; b < 256; b++) begin
         bit legal;
         logic [4:0] x;
         logic [2:0] y;
         x = 5'(b); y = 3'(b >> 5);
         legal = (x == 5'd28) || (y == 3'd7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
         step(1'b1, 1'b1, 8'(b), 2'b00);
         chk("R8 err flag", {9'd0, last_err}, {9'd0, !legal});
         if (!legal)
            chk("R8 substitute idle", last_word, idle_for(rd_before));
         else if (x == 5'd28)
            chk("R7 K28 sub-block", {4'd0, last_word[5:0]}, rd_before ? 10'h003 : 10'h03C);
         else
            chk("R7 Kx.7 sub-block", {4'd0, last_word[5:0]}, {4'd0, cw[rd_before][b][5:0]});
      end

      // R9 / R11: forced encodings, each followed by an idle
      run_chk = 0;
      for (int b = 0; b < 256; b++) begin
         step(1'b1, 1'b0, 8'(b), 2'b01);
         chk("R9 force plus", last_word, cw[0][b]);
         step(1'b0, 1'b0, 8'h00, 2'b00);
         chk("R11 state after force", last_word, idle_for(rd_before));
         step(1'b1, 1'b0, 8'(b), 2'b10);
         chk("R9 force minus", last_word, cw[1][b]);
         step(1'b0, 1'b0, 8'h00, 2'b00);
         chk("R11 state after force", last_word, idle_for(rd_before));
      end

      // R10: neutral-only character
      for (int k = 0; k < 3; k++) begin
         step(1'b1, 1'b0, 8'hB5, 2'(k));
         chk("R10 neutral only", last_word, 10'h155);
      end

      // R12: reserved balance acts as auto
      for (int b = 0; b < 256; b += 5) begin
         step(1'b1, 1'b0, 8'(b), 2'b11);
         chk("R12 reserved as auto", last_word, cw[rd_before][b]);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule